// File: doc/BRIEF.md
# Circular Receive Buffer Frame Writer

This block takes received Ethernet frames as a byte stream and stores them in a byte-addressed ring of memory. The ring runs from a programmable first address to a programmable last address. When a frame begins, the block reserves six bytes at the current hardware write pointer. It then streams the frame bytes in after that gap. Once the frame ends with an accept verdict, it goes back and fills the gap with a header: a 16-bit pointer to where the next frame will start, followed by a 32-bit status word.

Only after the header is in place does the block publish the frame. It moves the hardware write pointer, adds one to the count of frames waiting for the host, and raises an interrupt if that source is enabled. A frame rejected by the upstream filter leaves no trace. A frame that would run into the host's read pointer is abandoned and sets a sticky error flag. The host gives frames back by moving its read pointer and pulsing a decrement strobe.

Top module: `rx_ring_writer`

## Requirements
- R1: For a committed frame, the header is written to the six ring addresses starting at the frame start, wrapping as needed. The bytes, in order, are: next-frame pointer bits [7:0], next-frame pointer bits [15:8], then status bits [7:0], [15:8], [23:16] and [31:24].
- R2: Frame bytes are written in arrival order, starting six addresses after the frame start. The address after `bufEnd` is `bufStart`.
- R3: Status bits [15:0] hold the number of bytes received for the frame. Bit 23 holds `inRxOk` as sampled with `inEnd`. Every other status bit is zero.
- R4: The next-frame pointer is the address that follows the last frame byte. If that address is odd, one more address is skipped, with wrap in both steps. With an even `bufStart` and an odd `bufEnd`, every frame therefore starts on an even address.
- R5: When an accepted frame commits, `hwWrPtr` becomes the next-frame pointer and `pktCount` rises by one, saturating at its maximum. `pktPending` is high whenever `pktCount` is nonzero.
- R6: A frame ended with `inAccept` low changes neither `hwWrPtr`, nor `pktCount`, nor `rxErrFlag`, as long as it did not overflow first.
- R7: Let free space F be the distance from `hwWrPtr` forward to `hostRdPtr`, taken as the full ring size when the two are equal. The frame is dropped as an overflow when six header bytes plus the bytes received so far reach F. For an accepted frame, the pad byte also counts toward that total. On overflow, `rxErrFlag` sets and `hwWrPtr` does not move.
- R8: While `rxEnable` is low and no frame is in progress, `hwWrPtr` tracks `bufStart`, and any frame that starts is ignored.
- R9: A `decPkt` pulse lowers a nonzero `pktCount` by one. When the count reaches zero, `pktPending` drops.
- R10: `rxErrFlag` stays set until a `rxErrClr` pulse. `irq` equals `globalIntEn & ((pktIntEn & pktPending) | (errIntEn & rxErrFlag))`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Reception enable |
| bufStart | input | ADDR_W | First ring address (even) |
| bufEnd | input | ADDR_W | Last ring address (odd) |
| hostRdPtr | input | ADDR_W | First byte still owned by the host |
| inStart | input | 1 | Frame start pulse |
| inValid | input | 1 | Frame byte strobe |
| inData | input | 8 | Frame byte |
| inEnd | input | 1 | Frame end pulse |
| inAccept | input | 1 | Filter verdict, sampled with inEnd |
| inRxOk | input | 1 | Frame-good status, sampled with inEnd |
| decPkt | input | 1 | Host releases one frame |
| rxErrClr | input | 1 | Clears the overflow flag |
| pktIntEn | input | 1 | Frame-pending interrupt enable |
| errIntEn | input | 1 | Overflow interrupt enable |
| globalIntEn | input | 1 | Global interrupt enable |
| memWe | output | 1 | Ring memory write strobe |
| memAddr | output | ADDR_W | Ring memory write address |
| memData | output | 8 | Ring memory write data |
| hwWrPtr | output | ADDR_W | Start address of the next frame to be written |
| pktCount | output | CNT_W | Committed frames not yet released |
| pktPending | output | 1 | pktCount is nonzero |
| rxErrFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the following about the inputs:
- `bufStart` is even and `bufEnd` is odd and above it.
- Both stay fixed while `rxEnable` is high.
- `inStart`, `inValid` and `inEnd` are never high in the same cycle.
- At least six idle cycles follow each `inEnd`.

Under these conditions the write pointer stays even and inside the ring, and it moves only when the frame count changes.

The stimulus follows the same rules. Ring bounds change only while reception is off. Each frame is sent as separate start, byte and end cycles followed by a long gap. The read pointer is only ever set to an even, already-committed write pointer.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;

  localparam int HDR_LEN = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_DROP,
    ST_HDR
  } ringState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic       holdStart;  // track bufStart while disabled
    logic       loadStart;  // open a new frame at hwWrPtr
    logic       takeByte;   // store one frame byte
    logic       loadEnd;    // latch next pointer and status
    logic       writeHdr;   // write one header byte
    logic [2:0] hdrIdx;     // which header byte
    logic       commit;     // publish the frame
  } ringCmd_t;

endpackage

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringCmd_t          cmd,
  input  logic [ADDR_W-1:0] bufStart,
  input  logic [ADDR_W-1:0] bufEnd,
  input  logic [ADDR_W-1:0] hostRdPtr,
  input  logic [7:0]        inData,
  input  logic              inRxOk,
  output logic              headerFits,
  output logic              spaceZero,
  output logic              padNeeded,
  output logic [ADDR_W-1:0] hwWrPtr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  localparam int SW = ADDR_W + 1;

  logic [ADDR_W-1:0] frameStart;
  logic [ADDR_W-1:0] writePtr;
  logic [ADDR_W-1:0] nextPtr;
  logic [SW-1:0]     spaceLeft;
  logic [15:0]       byteCount;
  logic [31:0]       statusVec;
  logic [SW-1:0]     ringSize;
  logic [SW-1:0]     freeSpace;
  logic [SW-1:0]     gap;
  logic [7:0]        hdrByte [HDR_LEN];
  logic [15:0]       nextPtr16;

  function automatic logic [ADDR_W-1:0] wrapAdd(
    input logic [ADDR_W-1:0] a,
    input logic [SW-1:0]     k,
    input logic [ADDR_W-1:0] lo,
    input logic [ADDR_W-1:0] hi
  );
    logic [SW-1:0] s;
    logic [SW-1:0] sz;
    sz = {1'b0, hi} - {1'b0, lo} + SW'(1);
    s  = {1'b0, a} + k;
    if (s > {1'b0, hi}) s = s - sz;
    return s[ADDR_W-1:0];
  endfunction

  // Free space from write pointer forward to host read pointer
  always_comb begin
    ringSize = {1'b0, bufEnd} - {1'b0, bufStart} + SW'(1);
    gap      = '0;
    if (hostRdPtr >= hwWrPtr) begin
      gap       = {1'b0, hostRdPtr} - {1'b0, hwWrPtr};
      freeSpace = (gap == '0) ? ringSize : gap;
    end else begin
      freeSpace = ringSize - ({1'b0, hwWrPtr} - {1'b0, hostRdPtr});
    end
  end

  assign headerFits = freeSpace > SW'(HDR_LEN);
  assign spaceZero  = (spaceLeft == '0);
  assign padNeeded  = writePtr[0];
  assign nextPtr16  = 16'(nextPtr);

  // Header byte order: pointer low, pointer high, status LSB..MSB
  generate
    for (genvar g = 0; g < HDR_LEN; g++) begin : g_hdr
      if (g < 2) begin : g_ptr
        assign hdrByte[g] = nextPtr16[8*g +: 8];
      end else begin : g_stat
        assign hdrByte[g] = statusVec[8*(g-2) +: 8];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwWrPtr    <= '0;
      frameStart <= '0;
      writePtr   <= '0;
      nextPtr    <= '0;
      spaceLeft  <= '0;
      byteCount  <= '0;
      statusVec  <= '0;
      memWe      <= 1'b0;
      memAddr    <= '0;
      memData    <= '0;
    end else begin
      memWe <= 1'b0;
      if (cmd.holdStart) hwWrPtr <= bufStart;
      if (cmd.loadStart) begin
        frameStart <= hwWrPtr;
        writePtr   <= wrapAdd(hwWrPtr, SW'(HDR_LEN), bufStart, bufEnd);
        byteCount  <= '0;
        spaceLeft  <= freeSpace - SW'(HDR_LEN + 1);
      end
      if (cmd.takeByte) begin
        memWe     <= 1'b1;
        memAddr   <= writePtr;
        memData   <= inData;
        writePtr  <= wrapAdd(writePtr, SW'(1), bufStart, bufEnd);
        byteCount <= byteCount + 16'd1;
        spaceLeft <= spaceLeft - SW'(1);
      end
      if (cmd.loadEnd) begin
        nextPtr   <= writePtr[0] ? wrapAdd(writePtr, SW'(1), bufStart, bufEnd) : writePtr;
        statusVec <= {8'h00, inRxOk, 7'h00, byteCount};
      end
      if (cmd.writeHdr) begin
        memWe   <= 1'b1;
        memAddr <= wrapAdd(frameStart, SW'(cmd.hdrIdx), bufStart, bufEnd);
        memData <= hdrByte[cmd.hdrIdx];
      end
      if (cmd.commit) hwWrPtr <= nextPtr;
    end
  end

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             inStart,
  input  logic             inValid,
  input  logic             inEnd,
  input  logic             inAccept,
  input  logic             decPkt,
  input  logic             rxErrClr,
  input  logic             pktIntEn,
  input  logic             errIntEn,
  input  logic             globalIntEn,
  input  logic             headerFits,
  input  logic             spaceZero,
  input  logic             padNeeded,
  output ringCmd_t         cmd,
  output logic [CNT_W-1:0] pktCount,
  output logic             pktPending,
  output logic             rxErrFlag,
  output logic             irq
);

  localparam logic [2:0] LAST_HDR = 3'(HDR_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  ringState_t state, stateNxt;
  logic [2:0] hdrCnt, hdrCntNxt;
  logic       raiseErr;
  logic       cntUp, cntDown;

  always_comb begin
    cmd       = '0;
    stateNxt  = state;
    hdrCntNxt = hdrCnt;
    raiseErr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cmd.holdStart = !rxEnable;
        if (rxEnable && inStart) begin
          cmd.loadStart = 1'b1;
          if (headerFits) begin
            stateNxt = ST_DATA;
          end else begin
            raiseErr = 1'b1;
            stateNxt = ST_DROP;
          end
        end
      end
      ST_DATA: begin
        if (inValid) begin
          if (spaceZero) begin
            raiseErr = 1'b1;
            stateNxt = ST_DROP;
          end else begin
            cmd.takeByte = 1'b1;
          end
        end else if (inEnd) begin
          if (!inAccept) begin
            stateNxt = ST_IDLE;
          end else if (padNeeded && spaceZero) begin
            raiseErr = 1'b1;
            stateNxt = ST_IDLE;
          end else begin
            cmd.loadEnd = 1'b1;
            hdrCntNxt   = '0;
            stateNxt    = ST_HDR;
          end
        end
      end
      ST_DROP: begin
        if (inEnd) stateNxt = ST_IDLE;
      end
      ST_HDR: begin
        cmd.writeHdr = 1'b1;
        cmd.hdrIdx   = hdrCnt;
        if (hdrCnt == LAST_HDR) begin
          cmd.commit = 1'b1;
          stateNxt   = ST_IDLE;
        end else begin
          hdrCntNxt = hdrCnt + 3'd1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign cntUp   = cmd.commit && (pktCount != CNT_MAX);
  assign cntDown = decPkt && (pktCount != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hdrCnt    <= '0;
      pktCount  <= '0;
      rxErrFlag <= 1'b0;
    end else begin
      state  <= stateNxt;
      hdrCnt <= hdrCntNxt;
      if (cntUp && !cntDown) pktCount <= pktCount + 1'b1;
      else if (cntDown && !cntUp) pktCount <= pktCount - 1'b1;
      if (raiseErr) rxErrFlag <= 1'b1;
      else if (rxErrClr) rxErrFlag <= 1'b0;
    end
  end

  assign pktPending = (pktCount != '0);
  assign irq = globalIntEn && ((pktIntEn && pktPending) || (errIntEn && rxErrFlag));

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic [ADDR_W-1:0] bufStart,
  input  logic [ADDR_W-1:0] bufEnd,
  input  logic [ADDR_W-1:0] hostRdPtr,
  input  logic              inStart,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inEnd,
  input  logic              inAccept,
  input  logic              inRxOk,
  input  logic              decPkt,
  input  logic              rxErrClr,
  input  logic              pktIntEn,
  input  logic              errIntEn,
  input  logic              globalIntEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [ADDR_W-1:0] hwWrPtr,
  output logic [CNT_W-1:0]  pktCount,
  output logic              pktPending,
  output logic              rxErrFlag,
  output logic              irq
);

  ringCmd_t cmd;
  logic     headerFits, spaceZero, padNeeded;

  rx_ring_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .inStart    (inStart),
    .inValid    (inValid),
    .inEnd      (inEnd),
    .inAccept   (inAccept),
    .decPkt     (decPkt),
    .rxErrClr   (rxErrClr),
    .pktIntEn   (pktIntEn),
    .errIntEn   (errIntEn),
    .globalIntEn(globalIntEn),
    .headerFits (headerFits),
    .spaceZero  (spaceZero),
    .padNeeded  (padNeeded),
    .cmd        (cmd),
    .pktCount   (pktCount),
    .pktPending (pktPending),
    .rxErrFlag  (rxErrFlag),
    .irq        (irq)
  );

  rx_ring_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .bufStart  (bufStart),
    .bufEnd    (bufEnd),
    .hostRdPtr (hostRdPtr),
    .inData    (inData),
    .inRxOk    (inRxOk),
    .headerFits(headerFits),
    .spaceZero (spaceZero),
    .padNeeded (padNeeded),
    .hwWrPtr   (hwWrPtr),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memData   (memData)
  );

endmodule

// File: rtl/rx_ring_checker.sv
module rx_ring_checker #(
  parameter int ADDR_W = 13,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic [ADDR_W-1:0] bufStart,
  input logic [ADDR_W-1:0] bufEnd,
  input logic              decPkt,
  input logic              rxErrClr,
  input logic              pktIntEn,
  input logic              errIntEn,
  input logic              globalIntEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] hwWrPtr,
  input logic [CNT_W-1:0]  pktCount,
  input logic              pktPending,
  input logic              rxErrFlag,
  input logic              irq
);

  AST_MEM_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && rxEnable) |-> (memAddr >= bufStart && memAddr <= bufEnd)); // R2

  AST_WRPTR_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    rxEnable |-> (hwWrPtr[0] == 1'b0 && hwWrPtr >= bufStart && hwWrPtr <= bufEnd)); // R4

  AST_PTR_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && $past(rxEnable) && hwWrPtr != $past(hwWrPtr))
      |-> (pktCount != $past(pktCount) || $past(decPkt) || $past(pktCount) == '1)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pktCount == $past(pktCount) || pktCount == $past(pktCount) + 1'b1
      || pktCount == $past(pktCount) - 1'b1)); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rxErrFlag) && !$past(rxErrClr)) |-> rxErrFlag); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (globalIntEn && ((pktIntEn && pktPending) || (errIntEn && rxErrFlag)))); // R10

  AST_PENDING_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (pktCount == '0) |-> !pktPending); // R9

endmodule

bind rx_ring_writer rx_ring_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxEnable   (rxEnable),
  .bufStart   (bufStart),
  .bufEnd     (bufEnd),
  .decPkt     (decPkt),
  .rxErrClr   (rxErrClr),
  .pktIntEn   (pktIntEn),
  .errIntEn   (errIntEn),
  .globalIntEn(globalIntEn),
  .memWe      (memWe),
  .memAddr    (memAddr),
  .hwWrPtr    (hwWrPtr),
  .pktCount   (pktCount),
  .pktPending (pktPending),
  .rxErrFlag  (rxErrFlag),
  .irq        (irq)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;

  localparam int AW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxEnable = 1'b0;
  logic [AW-1:0] bufStart = 8'h10;
  logic [AW-1:0] bufEnd = 8'h4F;
  logic [AW-1:0] hostRdPtr = 8'h10;
  logic          inStart = 1'b0, inValid = 1'b0, inEnd = 1'b0;
  logic [7:0]    inData = 8'h00;
  logic          inAccept = 1'b0, inRxOk = 1'b0;
  logic          decPkt = 1'b0, rxErrClr = 1'b0;
  logic          pktIntEn = 1'b1, errIntEn = 1'b1, globalIntEn = 1'b1;
  logic          memWe;
  logic [AW-1:0] memAddr;
  logic [7:0]    memData;
  logic [AW-1:0] hwWrPtr;
  logic [CW-1:0] pktCount;
  logic          pktPending, rxErrFlag, irq;

  logic [7:0] mem [256];

  int checks = 0;
  int fails  = 0;
  int refWr, refCount, ringLo, ringSize;
  bit refErr;

  always #10 clk = ~clk;

  rx_ring_writer #(.ADDR_W(AW), .CNT_W(CW)) i_rx_ring_writer (.*);

  always @(posedge clk) if (memWe) mem[memAddr] <= memData;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wrapA(input int x);
    return ringLo + ((x - ringLo) % ringSize);
  endfunction

  task automatic sendFrame(input int n, input bit acc, input bit ok, input int seed);
    @(negedge clk) inStart = 1'b1;
    @(negedge clk) inStart = 1'b0;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1;
      inData  = 8'(seed + i * 3);
      @(negedge clk);
    end
    inValid  = 1'b0;
    inEnd    = 1'b1;
    inAccept = acc;
    inRxOk   = ok;
    @(negedge clk);
    inEnd = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic pulseDec();
    decPkt = 1'b1;
    @(negedge clk);
    decPkt = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    while (refCount > 0) begin
      pulseDec();
      refCount--;
    end
    hostRdPtr = AW'(refWr);
  endtask

  // One frame with reference model and checks
  task automatic runFrame(input int n, input bit acc, input bit ok, input int seed);
    int freeB, pad, need, nxt;
    bit badMem;
    freeB = ((int'(hostRdPtr) - refWr) % ringSize + ringSize) % ringSize;
    if (freeB == 0) freeB = ringSize;
    pad  = n % 2;
    need = acc ? (6 + n + pad) : (6 + n);
    nxt  = wrapA(refWr + 6 + n + pad);
    sendFrame(n, acc, ok, seed);
    if (need >= freeB) begin
      chk(rxErrFlag == 1'b1, "R7 overflow flag", rxErrFlag, 1);
      chk(int'(hwWrPtr) == refWr, "R7 pointer held", hwWrPtr, refWr);
      chk(int'(pktCount) == refCount, "R7 count held", pktCount, refCount);
      refErr = 1'b1;
    end else if (!acc) begin
      chk(int'(hwWrPtr) == refWr, "R6 reject pointer", hwWrPtr, refWr);
      chk(int'(pktCount) == refCount, "R6 reject count", pktCount, refCount);
      chk(rxErrFlag == refErr, "R6 reject flag", rxErrFlag, refErr);
    end else begin
      badMem = 1'b0;
      for (int i = 0; i < n; i++)
        if (mem[wrapA(refWr + 6 + i)] != 8'(seed + i * 3)) badMem = 1'b1;
      chk(!badMem, "R2 frame bytes", badMem, 0);
      chk(mem[wrapA(refWr)] == 8'(nxt) && mem[wrapA(refWr + 1)] == 8'(nxt >> 8),
          "R1 next pointer bytes", {mem[wrapA(refWr + 1)], mem[wrapA(refWr)]}, nxt);
      chk(mem[wrapA(refWr + 2)] == 8'(n) && mem[wrapA(refWr + 3)] == 8'(n >> 8),
          "R3 byte count", {mem[wrapA(refWr + 3)], mem[wrapA(refWr + 2)]}, n);
      chk(mem[wrapA(refWr + 4)] == (ok ? 8'h80 : 8'h00) && mem[wrapA(refWr + 5)] == 8'h00,
          "R3 status high bytes", {mem[wrapA(refWr + 5)], mem[wrapA(refWr + 4)]},
          ok ? 32'h80 : 32'h0);
      refCount++;
      chk(int'(hwWrPtr) == nxt && hwWrPtr[0] == 1'b0, "R4 next pointer", hwWrPtr, nxt);
      chk(int'(pktCount) == refCount && pktPending, "R5 commit count", pktCount, refCount);
      refWr = nxt;
    end
    chk(irq == ((refCount != 0) || refErr), "R10 irq", irq, (refCount != 0) || refErr);
    if (refErr) begin
      rxErrClr = 1'b1;
      @(negedge clk);
      rxErrClr = 1'b0;
      @(negedge clk);
      refErr = 1'b0;
      chk(rxErrFlag == 1'b0, "R10 flag cleared", rxErrFlag, 0);
    end
  endtask

  task automatic setRing(input int lo, input int hi);
    @(negedge clk);
    rxEnable = 1'b0;
    bufStart = AW'(lo);
    bufEnd   = AW'(hi);
    ringLo   = lo;
    ringSize = hi - lo + 1;
    repeat (3) @(negedge clk);
    chk(int'(hwWrPtr) == lo, "R8 pointer follows start", hwWrPtr, lo);
    refWr     = lo;
    hostRdPtr = AW'(lo);
    rxEnable  = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    refCount = 0;
    refErr   = 1'b0;
    ringLo   = 16;
    ringSize = 64;
    refWr    = 16;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(memWe == 1'b0, "R5 reset write strobe", memWe, 0);
    chk(pktCount == '0 && !pktPending, "R5 reset count", pktCount, 0);
    chk(rxErrFlag == 1'b0 && irq == 1'b0, "R10 reset flags", {rxErrFlag, irq}, 0);
    chk(hwWrPtr == bufStart, "R8 reset pointer", hwWrPtr, bufStart);

    // Disabled reception ignores a frame
    sendFrame(9, 1'b1, 1'b1, 5);
    chk(pktCount == '0, "R8 disabled count", pktCount, 0);
    chk(hwWrPtr == bufStart, "R8 disabled pointer", hwWrPtr, bufStart);

    for (int cfg = 0; cfg < 3; cfg++) begin
      case (cfg)
        0: setRing(8'h10, 8'h4F);
        1: setRing(8'hC0, 8'hFF);
        default: setRing(8'h00, 8'h27);
      endcase
      for (int k = 0; k < 30; k++) begin
        runFrame(1 + (k * 7 + cfg * 5) % 29, (k % 4) != 3, k[0], k * 11 + cfg);
        if (k % 3 == 2) drain();
      end
      drain();
      chk(!pktPending && pktCount == '0, "R9 drained", pktCount, 0);
    end

    // Interrupt gating with a pending frame
    runFrame(4, 1'b1, 1'b1, 77);
    globalIntEn = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10 global gate", irq, 0);
    globalIntEn = 1'b1;
    pktIntEn    = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R10 source gate", irq, 0);
    pktIntEn = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 source on", irq, 1);
    pulseDec();
    refCount--;
    chk(pktCount == '0 && !pktPending, "R9 decrement to zero", pktCount, 0);
    pulseDec();
    chk(pktCount == '0, "R9 decrement at zero", pktCount, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule